// File: doc/BRIEF.md
# Intra-train bunch position feedback controller

This block is the digital core of a fast beam-position feedback loop that acts within a single short train of particle bunches. Each plane has its own channel. A channel takes signed position samples from an ADC, picks out the one sample that belongs to each bunch, and produces a signed correction word for a DAC that drives a kicker magnet. The first bunch of a train is only measured. Each bunch after it gets a correction equal to the correction already applied plus a gain times the position of the bunch before it. The accumulated term is the delay loop, and it is what keeps a kick in place for the rest of the train.

A train-start trigger restarts a counter of valid samples. A programmable offset and a programmable spacing, both in valid samples, choose which samples are the bunch samples. Because the whole loop has a hard latency budget, each channel is a short fixed pipeline. Its DAC word changes a fixed number of cycles after the chosen sample. The word holds between bunches and drops to zero after the last bunch. An enable input allows open-loop running: positions are still captured and brought out, but the DAC word stays at zero.

Top module: `bfb_ctrl`

## Requirements
- R1: After reset, every `dac_o` field and every `pos_o` field is zero, and no train is active.
- R2: Counting from 0 the cycles with `samp_vld_i` high that follow the trigger cycle, bunch b (0-based) takes the sample with index `first_ofs_i + b*spacing_i`. Offset and spacing are sampled in the trigger cycle. A spacing of 0 acts as 1. A sample presented in the trigger cycle itself is not counted.
- R3: The two's complement position of bunch b on channel c appears in `pos_o[(c*NUM_BUNCH+b)*SAMP_W +: SAMP_W]` from the edge that takes the sample. It holds until that bunch is taken again, whatever the state of `loop_en_i`.
- R4: When the first bunch is sampled, the DAC word is zero. The sample of bunch b (b < NUM_BUNCH-1) sets the DAC word to sat(previous word + floor(gain*position / 2^GAIN_FRAC)). The gain is a two's complement value with GAIN_FRAC fraction bits.
- R5: Between updates the DAC word holds its value, and that value is the previous word that the next update adds to (the delay loop).
- R6: The result saturates to the signed range of DAC_W bits, -2^(DAC_W-1) to 2^(DAC_W-1)-1.
- R7: The last bunch's sample returns the DAC word to zero, with the same latency as an update. Later samples are ignored until the next trigger, and positions stay unchanged.
- R8: A DAC update caused by a sample taken in cycle k is visible on `dac_o` from cycle k+3 (the third rising edge, counting the one that takes the sample).
- R9: While `loop_en_i` is low, the DAC word is zero from the next edge on. Positions are still captured.
- R10: A trigger clears the DAC word at its edge and discards updates still in the pipeline. If it falls on the edge of an update, the trigger wins. Selection then restarts.
- R11: The channels are independent. Channel c uses the fields `[c*W +: W]` of `samp_i`, `gain_i` and `dac_o`, where W is the width of the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Train-start trigger, one cycle |
| samp_vld_i | input | 1 | ADC sample valid |
| samp_i | input | NUM_CH*SAMP_W | Signed ADC samples, one field per channel |
| loop_en_i | input | 1 | Closed-loop enable; low gives open loop |
| gain_i | input | NUM_CH*GAIN_W | Signed fixed-point gain per channel |
| first_ofs_i | input | CNT_W | Valid samples from trigger to first bunch |
| spacing_i | input | CNT_W | Valid samples between bunches |
| pos_o | output | NUM_CH*NUM_BUNCH*SAMP_W | Captured bunch positions |
| dac_o | output | NUM_CH*DAC_W | Registered signed DAC correction words |

## Verification
A train-start trigger can arrive on the same edge at which a pending correction would be written to the DAC register, and the trigger has to win. The bench provokes this with a retrigger three cycles after the first trigger, using offset 0, spacing 4 and samples valid in every cycle. It judges the result by expecting a zero DAC word in the following cycle, where the update would otherwise have appeared. Random trains also drop the enable in cycles that carry an update, and a cycle-level model checks every DAC word against the update, hold, clear or zero that the requirements predict.

// File: rtl/bfb_pkg.sv
package bfb_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int idx_w(int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bfb_bunch_seq.sv
module bfb_bunch_seq
  import bfb_pkg::*;
#(
  parameter int NUM_BUNCH = 3,
  parameter int CNT_W     = 12,
  parameter int BW        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             samp_vld_i,
  input  logic [CNT_W-1:0] first_ofs_i,
  input  logic [CNT_W-1:0] spacing_i,
  output logic             pick_o,
  output logic [BW-1:0]    bunch_o,
  output logic             last_o
);

  localparam int TW = CNT_W + BW + 1;

  seq_state_e       state_q;
  logic [TW-1:0]    cnt_q;
  logic [TW-1:0]    tgt_q;
  logic [CNT_W-1:0] spc_q;
  logic [BW-1:0]    bunch_q;

  assign bunch_o = bunch_q;
  assign last_o  = (bunch_q == BW'(NUM_BUNCH - 1));
  assign pick_o  = (state_q == SEQ_RUN) && samp_vld_i && !trig_i && (cnt_q == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      spc_q   <= CNT_W'(1);
      bunch_q <= '0;
    end else if (trig_i) begin
      state_q <= SEQ_RUN;
      cnt_q   <= '0;
      tgt_q   <= TW'(first_ofs_i);
      spc_q   <= (spacing_i == '0) ? CNT_W'(1) : spacing_i;
      bunch_q <= '0;
    end else if (state_q == SEQ_RUN && samp_vld_i) begin
      cnt_q <= cnt_q + TW'(1);
      if (cnt_q == tgt_q) begin
        tgt_q <= tgt_q + TW'(spc_q);
        if (last_o) state_q <= SEQ_IDLE;
        else        bunch_q <= bunch_q + BW'(1);
      end
    end
  end

  AST_LAST_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_o && last_o && !trig_i) |=> (state_q == SEQ_IDLE))
    else $error("last bunch did not end the train"); // R7

  AST_TRIG_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (state_q == SEQ_RUN && bunch_q == '0 && cnt_q == '0))
    else $error("trigger did not restart selection"); // R10

endmodule

// File: rtl/bfb_chan_corr.sv
module bfb_chan_corr #(
  parameter int SAMP_W    = 14,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int DAC_W     = 14,
  parameter int NUM_BUNCH = 3,
  parameter int BW        = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          trig_i,
  input  logic                          loop_en_i,
  input  logic                          pick_i,
  input  logic [BW-1:0]                 bunch_i,
  input  logic                          last_i,
  input  logic signed [SAMP_W-1:0]      samp_i,
  input  logic signed [GAIN_W-1:0]      gain_i,
  output logic [NUM_BUNCH*SAMP_W-1:0]   pos_o,
  output logic signed [DAC_W-1:0]       dac_o
);

  localparam int PW = SAMP_W + GAIN_W;
  localparam int SW = ((PW > DAC_W) ? PW : DAC_W) + 1;
  localparam logic signed [SW-1:0] DAC_MAX = {{(SW-DAC_W+1){1'b0}}, {(DAC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] DAC_MIN = {{(SW-DAC_W+1){1'b1}}, {(DAC_W-1){1'b0}}};

  // stage 1: captured position
  logic                     s1_vld_q, s1_last_q;
  logic signed [SAMP_W-1:0] s1_pos_q;
  // stage 2: gain product
  logic                     s2_vld_q, s2_last_q;
  logic signed [PW-1:0]     s2_prod_q;
  // stage 3: delay-loop accumulator, drives the DAC
  logic signed [DAC_W-1:0]  corr_q, corr_nxt;
  logic signed [PW-1:0]     scaled;
  logic signed [SW-1:0]     sum;

  generate
    for (genvar b = 0; b < NUM_BUNCH; b++) begin : g_pos
      logic [SAMP_W-1:0] pos_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 pos_q <= '0;
        else if (pick_i && bunch_i == BW'(b))        pos_q <= samp_i;
      end
      assign pos_o[b*SAMP_W +: SAMP_W] = pos_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_last_q <= 1'b0;
      s1_pos_q  <= '0;
      s2_vld_q  <= 1'b0;
      s2_last_q <= 1'b0;
      s2_prod_q <= '0;
    end else begin
      s1_vld_q  <= pick_i && !trig_i;
      s1_last_q <= last_i;
      if (pick_i) s1_pos_q <= samp_i;
      s2_vld_q  <= s1_vld_q && !trig_i;
      s2_last_q <= s1_last_q;
      if (s1_vld_q) s2_prod_q <= PW'(gain_i) * PW'(s1_pos_q);
    end
  end

  always_comb begin
    scaled = s2_prod_q >>> GAIN_FRAC;
    sum    = SW'(scaled) + SW'(corr_q);
    if (sum > DAC_MAX)      corr_nxt = DAC_MAX[DAC_W-1:0];
    else if (sum < DAC_MIN) corr_nxt = DAC_MIN[DAC_W-1:0];
    else                    corr_nxt = sum[DAC_W-1:0];
  end

  // trigger has priority over a coinciding update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    corr_q <= '0;
    else if (trig_i || !loop_en_i)  corr_q <= '0;
    else if (s2_vld_q)              corr_q <= s2_last_q ? '0 : corr_nxt;
  end

  assign dac_o = corr_q;

  AST_TRIG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (dac_o == '0))
    else $error("trigger did not clear correction"); // R10

  AST_OPEN_LOOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |=> (dac_o == '0))
    else $error("open loop drove a correction"); // R9

  AST_LAST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld_q && s2_last_q) |=> (dac_o == '0))
    else $error("correction not returned to zero"); // R7

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s2_vld_q && loop_en_i && !trig_i) |=> $stable(dac_o))
    else $error("correction moved between bunches"); // R5

  AST_FIRST_UNKICKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pick_i && bunch_i == '0) |-> (dac_o == '0))
    else $error("first bunch saw a kick"); // R4

endmodule

// File: rtl/bfb_ctrl.sv
module bfb_ctrl
  import bfb_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int NUM_BUNCH = 3,
  parameter int SAMP_W    = 14,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  parameter int DAC_W     = 14,
  parameter int CNT_W     = 12
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 trig_i,
  input  logic                                 samp_vld_i,
  input  logic [NUM_CH*SAMP_W-1:0]             samp_i,
  input  logic                                 loop_en_i,
  input  logic [NUM_CH*GAIN_W-1:0]             gain_i,
  input  logic [CNT_W-1:0]                     first_ofs_i,
  input  logic [CNT_W-1:0]                     spacing_i,
  output logic [NUM_CH*NUM_BUNCH*SAMP_W-1:0]   pos_o,
  output logic [NUM_CH*DAC_W-1:0]              dac_o
);

  localparam int BW    = idx_w(NUM_BUNCH);
  localparam int POS_W = NUM_BUNCH * SAMP_W;

  logic          pick_w;
  logic [BW-1:0] bunch_w;
  logic          last_w;

  bfb_bunch_seq #(
    .NUM_BUNCH (NUM_BUNCH),
    .CNT_W     (CNT_W),
    .BW        (BW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .samp_vld_i  (samp_vld_i),
    .first_ofs_i (first_ofs_i),
    .spacing_i   (spacing_i),
    .pick_o      (pick_w),
    .bunch_o     (bunch_w),
    .last_o      (last_w)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      bfb_chan_corr #(
        .SAMP_W    (SAMP_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .DAC_W     (DAC_W),
        .NUM_BUNCH (NUM_BUNCH),
        .BW        (BW)
      ) u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (trig_i),
        .loop_en_i (loop_en_i),
        .pick_i    (pick_w),
        .bunch_i   (bunch_w),
        .last_i    (last_w),
        .samp_i    (samp_i[c*SAMP_W +: SAMP_W]),
        .gain_i    (gain_i[c*GAIN_W +: GAIN_W]),
        .pos_o     (pos_o[c*POS_W +: POS_W]),
        .dac_o     (dac_o[c*DAC_W +: DAC_W])
      );

      AST_DAC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(dac_o[c*DAC_W +: DAC_W]) |->
          ($past(pick_w, 3) || $past(trig_i) || !$past(loop_en_i)))
        else $error("DAC word changed off the fixed latency"); // R8
    end
  endgenerate

endmodule

// File: tb/tb_bfb_ctrl.sv
module tb_bfb_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 2;
  localparam int NUM_BUNCH  = 3;
  localparam int SAMP_W     = 14;
  localparam int GAIN_W     = 16;
  localparam int GAIN_FRAC  = 12;
  localparam int DAC_W      = 14;
  localparam int CNT_W      = 12;
  localparam int MAXL       = 1024;
  localparam longint DMAX   = (64'sd1 <<< (DAC_W-1)) - 1;
  localparam longint DMIN   = -(64'sd1 <<< (DAC_W-1));

  logic                               clk, rst_n, trig, vld, en;
  logic [NUM_CH*SAMP_W-1:0]           samp;
  logic [NUM_CH*GAIN_W-1:0]           gain;
  logic [CNT_W-1:0]                   ofs, spc;
  logic [NUM_CH*NUM_BUNCH*SAMP_W-1:0] pos;
  logic [NUM_CH*DAC_W-1:0]            dac;

  bfb_ctrl #(
    .NUM_CH(NUM_CH), .NUM_BUNCH(NUM_BUNCH), .SAMP_W(SAMP_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .DAC_W(DAC_W), .CNT_W(CNT_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .samp_vld_i(vld), .samp_i(samp),
    .loop_en_i(en), .gain_i(gain), .first_ofs_i(ofs), .spacing_i(spc),
    .pos_o(pos), .dac_o(dac)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_chk = 0, n_fail = 0;
  bit     done = 0;
  longint exp_corr [NUM_CH];
  longint exp_pos  [NUM_CH][NUM_BUNCH];
  longint gain_m   [NUM_CH];
  bit     ev_v     [MAXL];
  bit     ev_last  [MAXL];
  longint ev_pos   [MAXL][NUM_CH];

  function automatic longint next_corr(longint c, longint g, longint p);
    longint s;
    s = c + ((g * p) >>> GAIN_FRAC);
    if (s > DMAX) s = DMAX;
    if (s < DMIN) s = DMIN;
    return s;
  endfunction

  function automatic longint dac_of(int c);
    return longint'($signed(dac[c*DAC_W +: DAC_W]));
  endfunction

  function automatic longint pos_of(int c, int b);
    return longint'($signed(pos[(c*NUM_BUNCH+b)*SAMP_W +: SAMP_W]));
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic set_gain(int c, longint g);
    gain[c*GAIN_W +: GAIN_W] = GAIN_W'(g);
    gain_m[c] = longint'($signed(gain[c*GAIN_W +: GAIN_W]));
  endtask

  // en_mode: 0 closed loop, 1 open loop, 2 random drops
  // samp_mode: 0 random, 1 full-scale extremes
  task automatic run_train(int t_ofs, int t_spc, int vld_pct, int en_mode,
                           int samp_mode, int retrig_at, string tag);
    bit     running;
    bit     prev_trig;
    bit     prev_en;
    int     cnt, b, lofs, lspc, last_pick;
    longint smp [NUM_CH];
    string  ct;
    running = 0; prev_trig = 0; prev_en = en;
    cnt = 0; b = 0; lofs = 0; lspc = 1; last_pick = -100;
    for (int i = 0; i < MAXL; i++) ev_v[i] = 0;
    for (int t = 0; t < MAXL-4; t++) begin
      @(negedge clk);
      if (prev_trig)                ct = "R10";
      else if (!prev_en)            ct = "R9";
      else if (ev_v[t] && ev_last[t]) ct = "R7";
      else if (ev_v[t])             ct = tag;
      else                          ct = "R5";
      for (int c = 0; c < NUM_CH; c++) begin
        if (prev_trig)    exp_corr[c] = 0;
        else if (ev_v[t]) exp_corr[c] = (!prev_en || ev_last[t]) ? 0 :
                                        next_corr(exp_corr[c], gain_m[c], ev_pos[t][c]);
        else if (!prev_en) exp_corr[c] = 0;
        chk(dac_of(c) == exp_corr[c], ct, $sformatf("dac ch%0d t=%0d", c, t),
            dac_of(c), exp_corr[c]);
      end
      if (t > 0 && !running && t > last_pick + 4 && t > retrig_at + 1) break;
      trig = (t == 0) || (t == retrig_at);
      vld  = (($urandom % 100) < vld_pct);
      en   = (en_mode == 1) ? 1'b0 : (en_mode == 2) ? (($urandom % 8) != 0) : 1'b1;
      if (trig) begin
        ofs = CNT_W'(t_ofs);
        spc = CNT_W'(t_spc);
      end else begin
        ofs = CNT_W'($urandom);
        spc = CNT_W'($urandom);
      end
      for (int c = 0; c < NUM_CH; c++) begin
        logic [SAMP_W-1:0] s;
        if (samp_mode == 1)
          s = ($urandom % 2) ? {1'b0, {(SAMP_W-1){1'b1}}} : {1'b1, {(SAMP_W-1){1'b0}}};
        else
          s = SAMP_W'($urandom);
        samp[c*SAMP_W +: SAMP_W] = s;
        smp[c] = longint'($signed(s));
      end
      if (trig) begin
        for (int i = t + 1; i < MAXL; i++) ev_v[i] = 0;
        running = 1; cnt = 0; b = 0; lofs = t_ofs;
        lspc = (t_spc == 0) ? 1 : t_spc;
      end else if (running && vld) begin
        if (cnt == lofs + b * lspc) begin
          ev_v[t+3] = 1;
          ev_last[t+3] = (b == NUM_BUNCH - 1);
          for (int c = 0; c < NUM_CH; c++) begin
            ev_pos[t+3][c] = smp[c];
            exp_pos[c][b]  = smp[c];
          end
          last_pick = t;
          b++;
          if (b == NUM_BUNCH) running = 0;
        end
        cnt++;
      end
      prev_trig = trig;
      prev_en   = en;
    end
    trig = 1'b0;
    vld  = 1'b0;
    // R3 / R2: captured positions, untouched by samples after the last bunch (R7)
    for (int c = 0; c < NUM_CH; c++)
      for (int b2 = 0; b2 < NUM_BUNCH; b2++)
        chk(pos_of(c, b2) == exp_pos[c][b2], "R3", $sformatf("pos ch%0d b%0d", c, b2),
            pos_of(c, b2), exp_pos[c][b2]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20260));
    rst_n = 1'b0; trig = 1'b0; vld = 1'b0; en = 1'b1;
    samp = '0; gain = '0; ofs = '0; spc = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      exp_corr[c] = 0;
      gain_m[c] = 0;
      for (int b = 0; b < NUM_BUNCH; b++) exp_pos[c][b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NUM_CH; c++) begin
      chk(dac_of(c) == 0, "R1", "dac after reset", dac_of(c), 0);
      for (int b = 0; b < NUM_BUNCH; b++)
        chk(pos_of(c, b) == 0, "R1", "pos after reset", pos_of(c, b), 0);
    end

    // R4: basic correction law, all samples valid
    set_gain(0, 4096); set_gain(1, -2048);
    run_train(2, 3, 100, 0, 0, -1, "R4");

    // R2: sparse valid samples, spacing 0 treated as 1
    set_gain(0, 1500); set_gain(1, 3000);
    run_train(0, 0, 40, 0, 0, -1, "R2");
    run_train(5, 7, 50, 0, 0, -1, "R2");

    // R6: saturation with full-scale gain and samples
    set_gain(0, 32767); set_gain(1, -32768);
    run_train(1, 2, 100, 0, 1, -1, "R6");
    run_train(3, 1, 70, 0, 1, -1, "R6");

    // R9: open loop, positions still captured
    set_gain(0, 8000); set_gain(1, 8000);
    run_train(1, 4, 100, 1, 0, -1, "R9");
    en = 1'b1;

    // R10: retrigger lands on the edge of the first update
    set_gain(0, 5000); set_gain(1, -7000);
    run_train(0, 4, 100, 0, 0, 3, "R10");

    // R8 / R11: random trains with per-channel gains
    for (int k = 0; k < 24; k++) begin
      set_gain(0, longint'($urandom));
      set_gain(1, longint'($urandom));
      run_train($urandom % 21, $urandom % 16, 30 + ($urandom % 71),
                (k % 4 == 3) ? 2 : 0, (k % 5 == 4) ? 1 : 0, -1,
                (k % 2) ? "R11" : "R8");
      en = 1'b1;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule